// File: doc/BRIEF.md
# Cascaded Twisted-Ring Seconds Counter

This block counts seconds from 0 to 59 using two twisted-ring (Johnson) chains whose stages are level-enabled storage elements rather than master-slave flip-flops. A five-stage units ring holds the seconds digit in ten states. A three-stage tens ring holds the tens digit in six states. Each stage has its own phase enable and is written only while that enable is high. The phases run from the last stage back to the first, so one complete phase cycle moves the ring one step without using a second storage rank.

The tens ring does not get phases of its own. It reuses the three lowest units phases, and these are gated by a flag that marks a phase cycle which began with the units digit at 9. Both ring states are decoded to one-hot digit lines with two-input terms on adjacent stages. A minute-carry strobe marks the phase cycle in which the tens digit returns from 5 to 0.

A phase source drives the enables. It asserts at most one enable per clock, in the order stage 5, 4, 3, 2, 1. Any number of idle clocks may fall between two phases.

Top module: `cascade_ring_seconds`

## Requirements
- R1: While `rst_n` is low, both rings read all zeros, `units_digit` and `tens_digit` read 1 (digit 0), and `min_carry` is 0.
- R2: Each complete phase cycle (`ph_en` one-hot in the order bit 4, 3, 2, 1, 0) advances the units ring one step. Written stage 1 to stage 5 (`units_ring` bit 0 to bit 4), the steps are 00000, 10000, 11000, 11100, 11110, 11111, 01111, 00111, 00011, 00001, then back to 00000.
- R3: Units stage k (bit k-1) changes only on a clock where `ph_en[k-1]` is high. On a clock with `ph_en` all zero, no output changes.
- R4: Stage k for k>1 takes the value of stage k-1. Stage 1 takes the inverse of stage 5 as it was before the current cycle's bit-4 phase.
- R5: `units_digit` is one-hot, and bit d is set when the units ring is in the d-th state of the R2 list.
- R6: The tens ring has three stages (bit 0 to bit 2) and steps through 000, 100, 110, 111, 011, 001. It advances only in a phase cycle that began with units at 9. Its bits are written on phases 2, 1 and 0 respectively, and never on phases 4 or 3.
- R7: `tens_digit` is one-hot, and bit d is set when the tens ring is in the d-th state of the R6 list.
- R8: `min_carry` rises on the phase-0 clock that completes the move of tens from 5 to 0. It falls on the next phase-0 clock, and it changes on no other clock.
- R9: Idle clocks inserted between phases do not change the count sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ph_en | input | 5 | Phase enables. Bit k-1 writes units stage k |
| units_ring | output | 5 | Raw units ring stages, stage 1 in bit 0 |
| tens_ring | output | 3 | Raw tens ring stages, stage 1 in bit 0 |
| units_digit | output | 10 | One-hot units digit |
| tens_digit | output | 6 | One-hot tens digit |
| min_carry | output | 1 | Minute carry, high for one phase cycle |

## Verification
The assertions assume the phase source never raises two enables on the same clock. They also assume each phase cycle visits bit 4 down to bit 0 exactly once, in that order. Without this, the feedback hold and the wrap flag would capture values from the wrong part of a cycle. The stimulus meets the assumption because it drives enables only through a task that walks the phases in descending order. That task sets one bit at a time and drops to zero on the idle clocks it inserts.

// File: rtl/csec_pkg.sv
package csec_pkg;
  localparam int MAX_STAGES = 8;

  // Two-input decode term of a twisted ring with n stages for digit d.
  function automatic logic ring_term(input logic [MAX_STAGES-1:0] s,
                                     input int n, input int d);
    logic r;
    if (d == 0)      r = !s[0] && !s[n-1];
    else if (d < n)  r = s[d-1] && !s[d];
    else if (d == n) r = s[0] && s[n-1];
    else             r = !s[d-n-1] && s[d-n];
    return r;
  endfunction
endpackage

// File: rtl/csec_twist_ring.sv
module csec_twist_ring #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stage_en,
  output logic [N-1:0] ring
);
  logic         fb_hold;
  logic [N-1:0] stage_q;

  // The last stage is written first in a cycle; keep its old value inverted for stage 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fb_hold <= 1'b1;
    else if (stage_en[N-1])    fb_hold <= ~stage_q[N-1];
  end

  for (genvar k = 0; k < N; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            stage_q[k] <= 1'b0;
        else if (stage_en[k])  stage_q[k] <= fb_hold;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            stage_q[k] <= 1'b0;
        else if (stage_en[k])  stage_q[k] <= stage_q[k-1];
      end
    end
  end

  assign ring = stage_q;
endmodule

// File: rtl/csec_ring_decode.sv
module csec_ring_decode #(
  parameter int N = 5,
  localparam int D = 2 * N
) (
  input  logic [N-1:0] ring,
  output logic [D-1:0] digit
);
  import csec_pkg::*;

  logic [MAX_STAGES-1:0] ring_ext;
  assign ring_ext = MAX_STAGES'(ring);

  for (genvar d = 0; d < D; d++) begin : g_term
    assign digit[d] = ring_term(ring_ext, N, d);
  end
endmodule

// File: rtl/cascade_ring_seconds.sv
module cascade_ring_seconds #(
  parameter int UNITS_N = 5,
  parameter int TENS_N  = 3,
  localparam int UNITS_D = 2 * UNITS_N,
  localparam int TENS_D  = 2 * TENS_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [UNITS_N-1:0] ph_en,
  output logic [UNITS_N-1:0] units_ring,
  output logic [TENS_N-1:0]  tens_ring,
  output logic [UNITS_D-1:0] units_digit,
  output logic [TENS_D-1:0]  tens_digit,
  output logic               min_carry
);
  logic              cycle_start;
  logic              units_wrap_evt;
  logic              tens_wrap_evt;
  logic              wrap_pend;
  logic              min_pend;
  logic              carry_q;
  logic [TENS_N-1:0] tens_en;

  assign cycle_start    = ph_en[UNITS_N-1];
  assign units_wrap_evt = cycle_start && units_digit[UNITS_D-1];
  assign tens_wrap_evt  = units_wrap_evt && tens_digit[TENS_D-1];
  assign tens_en        = ph_en[TENS_N-1:0] & {TENS_N{wrap_pend}};

  csec_twist_ring #(.N(UNITS_N)) u_units_ring (
    .clk(clk), .rst_n(rst_n), .stage_en(ph_en), .ring(units_ring)
  );

  csec_twist_ring #(.N(TENS_N)) u_tens_ring (
    .clk(clk), .rst_n(rst_n), .stage_en(tens_en), .ring(tens_ring)
  );

  csec_ring_decode #(.N(UNITS_N)) u_units_dec (
    .ring(units_ring), .digit(units_digit)
  );

  csec_ring_decode #(.N(TENS_N)) u_tens_dec (
    .ring(tens_ring), .digit(tens_digit)
  );

  // Wrap flags are sampled at the first phase, before any stage has moved.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_pend <= 1'b0;
      min_pend  <= 1'b0;
    end else if (cycle_start) begin
      wrap_pend <= units_wrap_evt;
      min_pend  <= tens_wrap_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         carry_q <= 1'b0;
    else if (ph_en[0])  carry_q <= min_pend;
  end

  assign min_carry = carry_q;
endmodule

// File: rtl/cascade_ring_seconds_checker.sv
module cascade_ring_seconds_checker #(
  parameter int UNITS_N = 5,
  parameter int TENS_N  = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [UNITS_N-1:0]   ph_en,
  input logic [UNITS_N-1:0]   units_ring,
  input logic [TENS_N-1:0]    tens_ring,
  input logic [2*UNITS_N-1:0] units_digit,
  input logic [2*TENS_N-1:0]  tens_digit,
  input logic                 min_carry
);
  assert_units_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(units_digit) == 1);

  assert_tens_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tens_digit) == 1);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_en == '0) |=> ($stable(units_ring) && $stable(tens_ring) && $stable(min_carry)));

  assert_tens_early_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_en[UNITS_N-1:TENS_N] != '0) |=> $stable(tens_ring));

  assert_carry_only_phase0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_en[0] |=> $stable(min_carry));

  assert_carry_at_tens_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(min_carry) |-> (tens_digit[0] && units_digit[0]));
endmodule

bind cascade_ring_seconds cascade_ring_seconds_checker #(
  .UNITS_N(UNITS_N), .TENS_N(TENS_N)
) u_checker (
  .clk(clk), .rst_n(rst_n), .ph_en(ph_en), .units_ring(units_ring),
  .tens_ring(tens_ring), .units_digit(units_digit), .tens_digit(tens_digit),
  .min_carry(min_carry)
);

// File: tb/cascade_ring_seconds_test.sv
module cascade_ring_seconds_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] ph_en = '0;
  logic [4:0] units_ring;
  logic [2:0] tens_ring;
  logic [9:0] units_digit;
  logic [5:0] tens_digit;
  logic       min_carry;

  int checks = 0;
  int errors = 0;
  int ref_u = 0;
  int ref_t = 0;
  logic ref_carry = 1'b0;
  logic [4:0] prev_u;
  logic [2:0] prev_t;
  logic       prev_c;
  bit monitor_on = 0;

  always #4 clk = ~clk;

  cascade_ring_seconds uut (
    .clk(clk), .rst_n(rst_n), .ph_en(ph_en), .units_ring(units_ring),
    .tens_ring(tens_ring), .units_digit(units_digit), .tens_digit(tens_digit),
    .min_carry(min_carry)
  );

  // Pattern of an n-stage twisted ring after c steps from all zeros.
  function automatic int twist_pattern(input int n, input int c);
    int p = 0;
    for (int k = 0; k < n; k++)
      if ((c <= n) ? (k < c) : (k >= c - n)) p |= (1 << k);
    return p;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  // Per-clock monitor, sampled 2 ns after the rising edge.
  always @(posedge clk) begin
    #2;
    if (monitor_on && rst_n) begin
      check("R3 units change outside phase", int'((units_ring ^ prev_u) & ~ph_en), 0);
      if (ph_en == '0)
        check("R3 idle clock change", int'({tens_ring ^ prev_t, min_carry ^ prev_c}), 0);
    end
    prev_u = units_ring;
    prev_t = tens_ring;
    prev_c = min_carry;
  end

  task automatic phase_cycle(input int gap);
    for (int k = 4; k >= 0; k--) begin
      @(negedge clk) ph_en = 5'(1 << k);
      for (int g = 0; g < gap; g++) @(negedge clk) ph_en = '0;
    end
    @(negedge clk) ph_en = '0;
    ref_u = (ref_u + 1) % 10;
    ref_carry = 1'b0;
    if (ref_u == 0) begin
      ref_t = (ref_t + 1) % 6;
      if (ref_t == 0) ref_carry = 1'b1;
    end
    check("R2 R4 units ring", int'(units_ring), twist_pattern(5, ref_u));
    check("R5 units digit", int'(units_digit), 1 << ref_u);
    check("R6 tens ring", int'(tens_ring), twist_pattern(3, ref_t));
    check("R7 tens digit", int'(tens_digit), 1 << ref_t);
    check("R8 minute carry", int'(min_carry), int'(ref_carry));
  endtask

  task automatic check_reset_state();
    check("R1 units ring", int'(units_ring), 0);
    check("R1 tens ring", int'(tens_ring), 0);
    check("R1 units digit", int'(units_digit), 1);
    check("R1 tens digit", int'(tens_digit), 1);
    check("R1 carry", int'(min_carry), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    monitor_on = 1;
    // R2 back-to-back phases for one minute
    for (int i = 0; i < 60; i++) phase_cycle(0);
    // R9 idle clocks between phases for another minute
    for (int i = 0; i < 60; i++) phase_cycle(1 + (i % 2));
    // R1 reset in mid count
    for (int i = 0; i < 7; i++) phase_cycle(0);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    ref_u = 0; ref_t = 0;
    phase_cycle(0);
    monitor_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule